// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a NOR flash device. Every bus write reaches it as a single-cycle strobe that carries an address and a data byte. The decoder matches these writes against the unlock-keyed command sequences and keeps track of the device mode. When a sequence completes, it sends a one-cycle request to the embedded program/erase controller. It also tells the read path where read data comes from: the array, the identification/protection code, or the controller status. The controller reports back through a busy flag and an error flag. A vector of per-block protect bits tells the decoder which blocks must not be programmed.

The command key lives in the low eleven address bits. The block number is taken from the address bits at and above `BLK_LSB`. Any write that breaks a sequence drops the decoder back to read mode without any other effect. An unlock-bypass mode shortens programming to two writes. A running block erase can be suspended and resumed repeatedly. While the controller reports an error, only a reset is accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `rd_src` is 0 (array) and every request output is low.
- R2: The unlock prefix is AA written to key address 555h and then 55 written to key address 2AAh. Only address bits 10:0 are compared, so any values in the upper address bits still match.
- R3: Reset is accepted in two forms: a single F0 write at any address, or the unlock prefix followed by F0. Either form returns `mode` to 0 from read or identification mode.
- R4: The unlock prefix followed by 90 at 555h sets `mode` to 1 (identification) and `rd_src` to 1. In this mode a read address with bits 1:0 = 10b gives `id_byte` = 01h if the block selected by bits 18:16 is protected, and 00h if it is not.
- R5: The unlock prefix, then A0 at 555h, then a fourth write raises `pgm_req` during that fourth strobe, with `tgt_addr`/`tgt_data` equal to the address and data of that write. `mode` is then 3 and `rd_src` is 2 (status) until the controller drops busy.
- R6: A program aimed at a block whose protect bit is set raises no request. The decoder returns to its home mode (read, or bypass).
- R7: The unlock prefix followed by 20 at 555h sets `mode` to 2 (bypass), with `rd_src` 0. In bypass, A0 followed by an address/data write programs, 90 followed by 00 exits to read, and all other writes are ignored. After a bypass program completes, the decoder returns to mode 2.
- R8: The unlock prefix, 80 at 555h, and the unlock prefix again are followed by a sixth write. If that write is 10 at 555h, it raises `chip_erase_req` and sets `mode` to 4. If it is 30 at any address, it raises `blk_erase_req` and sets `mode` to 5. At most one request output is high in any cycle.
- R9: In read or identification mode, a write that does not continue a valid sequence returns `mode` to 0 and raises no request.
- R10: While a program or chip erase runs (mode 3 or 4), all writes are ignored. During a block erase, B0 raises `suspend_req` and sets `mode` to 6. F0 raises `reset_req` and sets `mode` to 0. All other writes are ignored.
- R11: In suspend mode, 30 raises `resume_req` and returns `mode` to 5. Suspend and resume can repeat any number of times. While suspended, reads from the erasing block give `rd_src` 2, and reads from other blocks give 0.
- R12: While `ctl_err` is high, only a single F0 write is accepted. It raises `reset_req` and returns the decoder to mode 0, or to mode 2 if the failed program was issued from bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Current read address |
| ctl_busy | input | 1 | Controller busy flag |
| ctl_err | input | 1 | Controller error flag |
| blk_prot | input | NBLK | Per-block protect bits |
| pgm_req | output | 1 | Program request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| blk_erase_req | output | 1 | Block erase request pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| reset_req | output | 1 | Abort / error clear request pulse |
| tgt_addr | output | AW | Address carried with a request |
| tgt_data | output | 8 | Data carried with a request |
| rd_src | output | 2 | Read source: 0 array, 1 id, 2 status |
| id_byte | output | 8 | Identification / protection byte |
| mode | output | 3 | Current mode code |

## Verification
A wrong sequence step inside the decoder only shows up when the write that would complete the sequence arrives. At that point a request pulse is missing or unexpected during the same strobe, and `mode` is wrong one edge later. A wrong home-mode bit stays hidden until an operation ends or an error is reset, and then the decoder returns to read instead of bypass, or the reverse. A stale suspended-block number appears in `rd_src` as soon as a read address points into a different block.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int KEYW = 11;
  localparam logic [KEYW-1:0] KEY_A = 11'h555;
  localparam logic [KEYW-1:0] KEY_B = 11'h2AA;

  typedef enum logic [2:0] {
    MD_READ = 3'd0, MD_ASEL = 3'd1, MD_BYP = 3'd2, MD_PGM = 3'd3,
    MD_CHIP = 3'd4, MD_BLK = 3'd5, MD_SUSP = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3, SQ_BX
  } step_e;

  typedef enum logic [1:0] {
    RS_ARRAY = 2'd0, RS_ID = 2'd1, RS_STAT = 2'd2
  } rdsrc_e;

  typedef struct packed {
    logic key1;
    logic key2;
    logic at_a;
    logic c_f0;
    logic c_90;
    logic c_a0;
    logic c_20;
    logic c_80;
    logic c_10;
    logic c_30;
    logic c_b0;
    logic c_00;
  } tok_t;

  function automatic logic is_running(input mode_e m);
    return (m == MD_PGM) || (m == MD_CHIP) || (m == MD_BLK);
  endfunction

  function automatic logic [7:0] prot_code(input logic p);
    return {7'b0, p};
  endfunction
endpackage

// File: rtl/fcd_wrdec.sv
module fcd_wrdec
  import fcd_pkg::*;
(
  input  logic [KEYW-1:0] key_addr,
  input  logic [7:0]      data,
  output tok_t            tok
);
  logic at_a, at_b;
  assign at_a = (key_addr == KEY_A);
  assign at_b = (key_addr == KEY_B);

  always_comb begin
    tok.key1 = at_a && (data == 8'hAA);
    tok.key2 = at_b && (data == 8'h55);
    tok.at_a = at_a;
    tok.c_f0 = (data == 8'hF0);
    tok.c_90 = (data == 8'h90);
    tok.c_a0 = (data == 8'hA0);
    tok.c_20 = (data == 8'h20);
    tok.c_80 = (data == 8'h80);
    tok.c_10 = (data == 8'h10);
    tok.c_30 = (data == 8'h30);
    tok.c_b0 = (data == 8'hB0);
    tok.c_00 = (data == 8'h00);
  end
endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int BW = 3,
  localparam int NBLK = 1 << BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  tok_t            tok,
  input  logic [BW-1:0]   wr_blk,
  input  logic [NBLK-1:0] blk_prot,
  input  logic            ctl_busy,
  input  logic            ctl_err,
  output mode_e           mode_q,
  output logic [BW-1:0]   run_blk,
  output logic            pgm_req,
  output logic            chip_req,
  output logic            blk_req,
  output logic            susp_req,
  output logic            res_req,
  output logic            rst_req,
  output logic            seq_break
);
  step_e         step_q, step_d;
  mode_e         mode_d;
  logic          home_byp_q, home_byp_d;
  logic          fresh_q, fresh_d;
  logic [BW-1:0] blk_q, blk_d;
  mode_e         home_mode;
  logic          prot_hit;

  assign home_mode = home_byp_q ? MD_BYP : MD_READ;
  assign prot_hit  = blk_prot[wr_blk];
  assign run_blk   = blk_q;

  always_comb begin
    mode_d = mode_q; step_d = step_q; home_byp_d = home_byp_q;
    fresh_d = 1'b0; blk_d = blk_q;
    pgm_req = 1'b0; chip_req = 1'b0; blk_req = 1'b0;
    susp_req = 1'b0; res_req = 1'b0; rst_req = 1'b0; seq_break = 1'b0;
    if (is_running(mode_q) && !fresh_q && !ctl_busy && !ctl_err) begin
      mode_d = home_mode;
      step_d = SQ_IDLE;
    end else if (wr_stb) begin
      if (ctl_err) begin
        if (tok.c_f0) begin
          rst_req = 1'b1; mode_d = home_mode; step_d = SQ_IDLE;
        end
      end else begin
        unique case (mode_q)
          MD_PGM, MD_CHIP: ;
          MD_BLK: begin
            if (tok.c_b0) begin
              susp_req = 1'b1; mode_d = MD_SUSP;
            end else if (tok.c_f0) begin
              rst_req = 1'b1; mode_d = MD_READ;
            end
          end
          MD_SUSP: begin
            if (tok.c_30) begin
              res_req = 1'b1; mode_d = MD_BLK; fresh_d = 1'b1;
            end
          end
          MD_BYP: begin
            step_d = SQ_IDLE;
            if (step_q == SQ_PGM) begin
              if (!prot_hit) begin
                pgm_req = 1'b1; mode_d = MD_PGM; fresh_d = 1'b1;
              end
            end else if (step_q == SQ_BX) begin
              if (tok.c_00) begin
                mode_d = MD_READ; home_byp_d = 1'b0;
              end
            end else if (tok.c_a0) step_d = SQ_PGM;
            else if (tok.c_90) step_d = SQ_BX;
          end
          default: begin
            step_d = SQ_IDLE;
            seq_break = 1'b0;
            unique case (step_q)
              SQ_IDLE:
                if (tok.c_f0) mode_d = MD_READ;
                else if (tok.key1) step_d = SQ_K1;
                else seq_break = 1'b1;
              SQ_K1:
                if (tok.key2) step_d = SQ_K2;
                else seq_break = 1'b1;
              SQ_K2:
                if (tok.c_f0) mode_d = MD_READ;
                else if (tok.at_a && tok.c_90) mode_d = MD_ASEL;
                else if (tok.at_a && tok.c_a0) step_d = SQ_PGM;
                else if (tok.at_a && tok.c_20) begin
                  mode_d = MD_BYP; home_byp_d = 1'b1;
                end else if (tok.at_a && tok.c_80) step_d = SQ_E1;
                else seq_break = 1'b1;
              SQ_PGM:
                if (prot_hit) mode_d = MD_READ;
                else begin
                  pgm_req = 1'b1; mode_d = MD_PGM; fresh_d = 1'b1;
                end
              SQ_E1:
                if (tok.key1) step_d = SQ_E2;
                else seq_break = 1'b1;
              SQ_E2:
                if (tok.key2) step_d = SQ_E3;
                else seq_break = 1'b1;
              SQ_E3:
                if (tok.at_a && tok.c_10) begin
                  chip_req = 1'b1; mode_d = MD_CHIP; fresh_d = 1'b1;
                end else if (tok.c_30) begin
                  blk_req = 1'b1; mode_d = MD_BLK; fresh_d = 1'b1; blk_d = wr_blk;
                end else seq_break = 1'b1;
              default: seq_break = 1'b1;
            endcase
            if (seq_break) mode_d = MD_READ;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_READ; step_q <= SQ_IDLE; home_byp_q <= 1'b0;
      fresh_q <= 1'b0; blk_q <= '0;
    end else begin
      mode_q <= mode_d; step_q <= step_d; home_byp_q <= home_byp_d;
      fresh_q <= fresh_d; blk_q <= blk_d;
    end
  end
endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter int BW = 3,
  localparam int NBLK = 1 << BW
) (
  input  mode_e           mode_q,
  input  logic [BW-1:0]   rd_blk,
  input  logic [1:0]      rd_low,
  input  logic [BW-1:0]   run_blk,
  input  logic [NBLK-1:0] blk_prot,
  output rdsrc_e          src,
  output logic [7:0]      id_byte
);
  always_comb begin
    if (mode_q == MD_ASEL) src = RS_ID;
    else if (is_running(mode_q)) src = RS_STAT;
    else if (mode_q == MD_SUSP && rd_blk == run_blk) src = RS_STAT;
    else src = RS_ARRAY;
  end

  assign id_byte = (mode_q == MD_ASEL && rd_low == 2'b10) ? prot_code(blk_prot[rd_blk]) : 8'h00;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 19,
  parameter int BLK_LSB = 16,
  localparam int BW = AW - BLK_LSB,
  localparam int NBLK = 1 << BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic            ctl_busy,
  input  logic            ctl_err,
  input  logic [NBLK-1:0] blk_prot,
  output logic            pgm_req,
  output logic            chip_erase_req,
  output logic            blk_erase_req,
  output logic            suspend_req,
  output logic            resume_req,
  output logic            reset_req,
  output logic [AW-1:0]   tgt_addr,
  output logic [7:0]      tgt_data,
  output logic [1:0]      rd_src,
  output logic [7:0]      id_byte,
  output logic [2:0]      mode
);
  tok_t          tok;
  mode_e         mode_q;
  rdsrc_e        src;
  logic [BW-1:0] run_blk;
  logic          seq_break;

  fcd_wrdec u_wrdec (
    .key_addr(wr_addr[KEYW-1:0]), .data(wr_data), .tok(tok)
  );

  fcd_ctrl #(.BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tok(tok),
    .wr_blk(wr_addr[AW-1:BLK_LSB]), .blk_prot(blk_prot),
    .ctl_busy(ctl_busy), .ctl_err(ctl_err), .mode_q(mode_q), .run_blk(run_blk),
    .pgm_req(pgm_req), .chip_req(chip_erase_req), .blk_req(blk_erase_req),
    .susp_req(suspend_req), .res_req(resume_req), .rst_req(reset_req),
    .seq_break(seq_break)
  );

  fcd_rdmux #(.BW(BW)) u_rdmux (
    .mode_q(mode_q), .rd_blk(rd_addr[AW-1:BLK_LSB]), .rd_low(rd_addr[1:0]),
    .run_blk(run_blk), .blk_prot(blk_prot), .src(src), .id_byte(id_byte)
  );

  assign tgt_addr = wr_addr;
  assign tgt_data = wr_data;
  assign rd_src   = src;
  assign mode     = mode_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW = 19,
  parameter int BLK_LSB = 16,
  localparam int NBLK = 1 << (AW - BLK_LSB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_stb,
  input logic            ctl_err,
  input logic [NBLK-1:0] blk_prot,
  input logic            pgm_req,
  input logic            chip_erase_req,
  input logic            blk_erase_req,
  input logic            suspend_req,
  input logic            resume_req,
  input logic            reset_req,
  input logic [AW-1:0]   tgt_addr,
  input logic [1:0]      rd_src,
  input logic [2:0]      mode,
  input logic            seq_break
);
  logic [5:0] reqs;
  logic       work_reqs;
  assign reqs = {pgm_req, chip_erase_req, blk_erase_req, suspend_req, resume_req, reset_req};
  assign work_reqs = pgm_req | chip_erase_req | blk_erase_req | suspend_req | resume_req;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs)); // R8
  AST_REQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (reqs != 6'd0) |-> wr_stb); // R5
  AST_PROT_NO_PGM: assert property (@(posedge clk) disable iff (!rst_n) pgm_req |-> !blk_prot[tgt_addr[AW-1:BLK_LSB]]); // R6
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd3 || mode == 3'd4 || mode == 3'd5) |-> rd_src == 2'd2); // R5
  AST_ERR_ONLY_RESET: assert property (@(posedge clk) disable iff (!rst_n) ctl_err |-> !work_reqs); // R12
  AST_BREAK_READ: assert property (@(posedge clk) disable iff (!rst_n) seq_break |=> mode == 3'd0); // R9
  AST_SUSP_FROM_BLK: assert property (@(posedge clk) disable iff (!rst_n) suspend_req |-> mode == 3'd5); // R10
  AST_SUSP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n) suspend_req |=> mode == 3'd6); // R10
  AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n) resume_req |-> mode == 3'd6); // R11
  AST_RUN_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) ((mode == 3'd3 || mode == 3'd4) && !ctl_err) |-> reqs == 6'd0); // R10
  AST_ASEL_ID: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd1) |-> rd_src == 2'd1); // R4
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .BLK_LSB(BLK_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ctl_err(ctl_err), .blk_prot(blk_prot),
  .pgm_req(pgm_req), .chip_erase_req(chip_erase_req), .blk_erase_req(blk_erase_req),
  .suspend_req(suspend_req), .resume_req(resume_req), .reset_req(reset_req),
  .tgt_addr(tgt_addr), .rd_src(rd_src), .mode(mode), .seq_break(seq_break)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic ctl_busy = 1'b0;
  logic ctl_err = 1'b0;
  logic [7:0] blk_prot = 8'b0010_0100;
  logic pgm_req, chip_erase_req, blk_erase_req, suspend_req, resume_req, reset_req;
  logic [AW-1:0] tgt_addr;
  logic [7:0] tgt_data, id_byte;
  logic [1:0] rd_src;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [5:0] cap;
  logic [AW-1:0] cap_addr;
  logic [7:0] cap_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ctl_busy(ctl_busy), .ctl_err(ctl_err), .blk_prot(blk_prot),
    .pgm_req(pgm_req), .chip_erase_req(chip_erase_req), .blk_erase_req(blk_erase_req),
    .suspend_req(suspend_req), .resume_req(resume_req), .reset_req(reset_req),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .rd_src(rd_src), .id_byte(id_byte), .mode(mode)
  );

  // request bit order: pgm, chip, blk, suspend, resume, reset
  localparam logic [5:0] Q_PGM = 6'b100000, Q_CHIP = 6'b010000, Q_BLK = 6'b001000;
  localparam logic [5:0] Q_SUS = 6'b000100, Q_RES = 6'b000010, Q_RST = 6'b000001;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1;
    cap = {pgm_req, chip_erase_req, blk_erase_req, suspend_req, resume_req, reset_req};
    cap_addr = tgt_addr; cap_data = tgt_data;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 19'h555, 8'hAA);
    wr(hi | 19'h2AA, 8'h55);
  endtask

  task automatic op_done(input string tag, input int exp_mode);
    @(negedge clk); ctl_busy = 1'b1;
    repeat (3) @(negedge clk);
    chk({tag, " busy status"}, rd_src, 2);
    ctl_busy = 1'b0;
    @(negedge clk);
    chk({tag, " return mode"}, mode, exp_mode);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 rd_src", rd_src, 0);
    chk("R1 reqs", {pgm_req, chip_erase_req, blk_erase_req, suspend_req, resume_req, reset_req}, 0);
  endtask

  task automatic t_asel();
    unlock(19'h7_8000);
    wr(19'h4_0555, 8'h90);
    chk("R2 upper bits ignored, R4 mode", mode, 1);
    chk("R4 rd_src", rd_src, 1);
    rd_addr = 19'h2_0002; #1;
    chk("R4 protected block code", id_byte, 8'h01);
    rd_addr = 19'h3_0002; #1;
    chk("R4 unprotected block code", id_byte, 8'h00);
    wr(19'h1_2345, 8'hF0);
    chk("R3 single F0", mode, 0);
    unlock(19'h0);
    wr(19'h555, 8'h90);
    unlock(19'h0);
    wr(19'h0_0123, 8'hF0);
    chk("R3 unlock F0", mode, 0);
    rd_addr = '0;
  endtask

  task automatic t_prog();
    unlock(19'h0);
    wr(19'h555, 8'hA0);
    chk("R5 no early req", cap, 0);
    wr(19'h1_2345, 8'h5A);
    chk("R5 pgm_req", cap, Q_PGM);
    chk("R5 tgt_addr", cap_addr, 19'h1_2345);
    chk("R5 tgt_data", cap_data, 8'h5A);
    chk("R5 mode", mode, 3);
    wr(19'h555, 8'hAA);
    chk("R10 write ignored in program", cap, 0);
    op_done("R5", 0);
  endtask

  task automatic t_prot();
    unlock(19'h0);
    wr(19'h555, 8'hA0);
    wr(19'h2_0010, 8'h11);
    chk("R6 no request", cap, 0);
    chk("R6 mode read", mode, 0);
  endtask

  task automatic t_break();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h12);
    chk("R9 bad second write", cap, 0);
    unlock(19'h0);
    wr(19'h556, 8'h90);
    chk("R9 wrong key address", mode, 0);
    unlock(19'h0);
    wr(19'h555, 8'h90);
    wr(19'h0_0040, 8'h77);
    chk("R9 leaves autoselect", mode, 0);
  endtask

  task automatic t_bypass();
    unlock(19'h0);
    wr(19'h555, 8'h20);
    chk("R7 bypass mode", mode, 2);
    chk("R7 array reads", rd_src, 0);
    wr(19'h0_0000, 8'hA0);
    wr(19'h6_0100, 8'hC3);
    chk("R7 two-write program", cap, Q_PGM);
    op_done("R7 bypass", 2);
    wr(19'h0, 8'hF0);
    chk("R7 other write ignored", mode, 2);
    wr(19'h0, 8'hA0);
    wr(19'h1_0000, 8'h00);
    chk("R7 second program", cap, Q_PGM);
    @(negedge clk); ctl_busy = 1'b1;
    @(negedge clk); ctl_err = 1'b1; ctl_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 error holds status", rd_src, 2);
    wr(19'h0, 8'hB0);
    chk("R12 non-reset ignored", cap, 0);
    wr(19'h0, 8'hF0);
    chk("R12 reset_req", cap, Q_RST);
    ctl_err = 1'b0;
    chk("R12 back to bypass", mode, 2);
    wr(19'h0, 8'h90);
    wr(19'h0, 8'h00);
    chk("R7 exit", mode, 0);
  endtask

  task automatic t_chip();
    unlock(19'h0); wr(19'h555, 8'h80);
    unlock(19'h0); wr(19'h555, 8'h10);
    chk("R8 chip_erase_req", cap, Q_CHIP);
    chk("R8 chip mode", mode, 4);
    wr(19'h0, 8'hB0);
    chk("R10 suspend ignored in chip erase", cap, 0);
    op_done("R8 chip", 0);
  endtask

  task automatic t_blk();
    unlock(19'h0); wr(19'h555, 8'h80);
    unlock(19'h0); wr(19'h3_0000, 8'h30);
    chk("R8 blk_erase_req", cap, Q_BLK);
    chk("R8 blk mode", mode, 5);
    @(negedge clk); ctl_busy = 1'b1;
    wr(19'h0, 8'hA0);
    chk("R10 other write ignored", mode, 5);
    for (int k = 0; k < 2; k++) begin
      wr(19'h0, 8'hB0);
      chk("R10 suspend_req", cap, Q_SUS);
      chk("R10 suspend mode", mode, 6);
      rd_addr = 19'h3_1234; #1;
      chk("R11 erasing block status", rd_src, 2);
      rd_addr = 19'h1_1234; #1;
      chk("R11 other block array", rd_src, 0);
      wr(19'h0, 8'h30);
      chk("R11 resume_req", cap, Q_RES);
      chk("R11 resumed mode", mode, 5);
    end
    wr(19'h0, 8'hF0);
    chk("R10 reset_req in block erase", cap, Q_RST);
    chk("R10 mode read", mode, 0);
    ctl_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_asel();
    t_prog();
    t_prot();
    t_break();
    t_bypass();
    t_chip();
    t_blk();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule